// File: doc/BRIEF.md
# Address Translation and Permission Checker

This block maps cartridge-space virtual addresses onto physical flash block addresses. It holds a table of 192 region descriptors. Each request carries a 30-bit address and a tag saying whether it is a programmed-I/O read or a DMA read. The block searches the table for a region that covers the address and checks the region's access rights for that request type. One cycle later it returns either a granted response or a refusal. A granted response carries the physical address, the device select and a flag that marks the cipher initial-vector region.

Software fills the table in two steps. First it loads a 9-bit upper field into a staging register. It then writes a 32-bit low word to a table index, and that write copies the staged upper field into the same entry. A refused request sets a sticky violation flag, one for PIO and one for DMA. The first refusal also captures the upper bits of the faulting address. That capture holds until software clears the flags.

Top module: `atb_xlate`

## Requirements
- R1: After synchronous reset, every response output and both violation flags are 0, the captured address is 0, and all table entries and the staging register are zero. A zero entry has no access rights, so any request after reset is refused.
- R2: A table write stores `tab_lo` as entry bits [31:0] and, in the same cycle, the staging register's value from before that clock edge as bits [40:32]. Later changes to the staging register do not alter entries that were already written.
- R3: Entry layout:
  - bits [15:0] hold the virtual block number;
  - bits [31:16] hold the physical block number;
  - bits [35:32] hold the size code S, which gives a region of 2^S blocks of 16 KB;
  - bits [37:36] hold the rights;
  - bits [39:38] hold the device;
  - bit 40 is the initial-vector flag.
  The request's block number is `req_addr[29:14]`. An entry covers the request when the two block numbers agree in every bit at or above bit S.
- R4: Every request with `req_valid` high produces `rsp_valid` high exactly one cycle later. On a grant, the response carries:
  - `rsp_phys` = {physical block number with its low S bits replaced by the request block's low S bits, `req_addr[13:0]`};
  - `rsp_dev`, the entry's device field;
  - `rsp_iv`, the entry's initial-vector flag.
- R5: Rights bit 37 permits PIO reads and bit 36 permits DMA reads. Rights 00 refuse both request types.
- R6: When several entries cover an address, only the lowest-indexed one is used, even if it refuses the request.
- R7: An address that no entry covers is refused.
- R8: A covering entry is refused if its device field is 3. It is also refused if its initial-vector flag is set while its size code is not 0 or its rights are not 11.
- R9: On a refusal, `rsp_ok`, `rsp_iv`, `rsp_dev` and `rsp_phys` are 0. The refusal sets `err_pio` for a PIO request (`req_dma`=0) or `err_dma` for a DMA request.
- R10: `err_addr` takes `req_addr[29:8]` from a refusal only if no flag stays set after this cycle's clears. Otherwise `err_addr` holds. Each flag stays set until its clear bit is high: `err_clr[0]` clears PIO and `err_clr[1]` clears DMA. A refusal arriving in the same cycle as the clear sets the flag again.
- R11: A table write to an index of 192 or above changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stage_we | input | 1 | Load the staging register |
| stage_d | input | 9 | Upper field {iv, dev[1:0], rights[1:0], size[3:0]} |
| tab_we | input | 1 | Write a table entry |
| tab_idx | input | 8 | Entry index |
| tab_lo | input | 32 | Entry low word {physical block, virtual block} |
| req_valid | input | 1 | Translation request |
| req_dma | input | 1 | 1 = DMA read, 0 = PIO read |
| req_addr | input | 30 | Virtual address |
| err_clr | input | 2 | Clear violation flags: bit 0 = PIO, bit 1 = DMA |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Request granted |
| rsp_iv | output | 1 | Granted entry supplies the initial vector |
| rsp_dev | output | 2 | Device select |
| rsp_phys | output | 30 | Physical address |
| err_pio | output | 1 | PIO violation flag |
| err_dma | output | 1 | DMA violation flag |
| err_addr | output | 22 | Captured faulting address bits [29:8] |

## Verification
A corrupted table entry or a staging register latched at the wrong time does not show up when it is written. It appears at the next request that reaches that entry: the one-cycle response then carries a wrong physical block or device, or a grant turns into a refusal. Each region is therefore probed directly after it is written, and again after the staging register has been changed. A wrong priority or masking decision shows on the first overlapping or edge-of-region probe, one cycle after the request. A flag or capture register that loses state shows on the next cycle's error outputs, because those outputs are compared on every clock.

// File: rtl/atb_pkg.sv
package atb_pkg;

    localparam int unsigned BLK_W  = 16;
    localparam int unsigned OFF_W  = 14;
    localparam int unsigned ADDR_W = BLK_W + OFF_W;
    localparam int unsigned LO_W   = 2 * BLK_W;
    localparam int unsigned UP_W   = 9;
    localparam int unsigned CAP_LO = 8;
    localparam int unsigned CAP_W  = ADDR_W - CAP_LO;

    // Bit order follows the written word: {upper staged field, low word}
    typedef struct packed {
        logic             iv;
        logic [1:0]       dev;
        logic [1:0]       rights;   // [1] PIO read, [0] DMA read
        logic [3:0]       size;
        logic [BLK_W-1:0] pblk;
        logic [BLK_W-1:0] vblk;
    } atb_entry_t;

    typedef struct packed {
        logic             ok;
        logic             iv;
        logic [1:0]       dev;
        logic [BLK_W-1:0] pblk;
    } atb_result_t;

    function automatic logic [BLK_W-1:0] low_mask(input logic [3:0] size);
        return (BLK_W'(1) << size) - BLK_W'(1);
    endfunction

    function automatic logic covers(input atb_entry_t e, input logic [BLK_W-1:0] vb);
        return ((e.vblk ^ vb) & ~low_mask(e.size)) == '0;
    endfunction

    function automatic logic well_formed(input atb_entry_t e);
        return (e.dev != 2'd3) && (!e.iv || (e.size == 4'd0 && e.rights == 2'b11));
    endfunction

    function automatic logic allows(input logic [1:0] rights, input logic is_dma);
        return is_dma ? rights[0] : rights[1];
    endfunction

endpackage

// File: rtl/atb_table.sv
module atb_table
    import atb_pkg::*;
#(
    parameter int unsigned N_ENTRIES = 192,
    localparam int unsigned IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stage_we,
    input  logic [UP_W-1:0]  stage_d,
    input  logic             tab_we,
    input  logic [IDX_W-1:0] tab_idx,
    input  logic [LO_W-1:0]  tab_lo,
    output atb_entry_t       tab_q [N_ENTRIES]
);

    logic [UP_W-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst)           stage_q <= '0;
        else if (stage_we) stage_q <= stage_d;
    end

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_entry
        atb_entry_t ent_q;
        always_ff @(posedge clk) begin
            if (rst)
                ent_q <= '0;
            else if (tab_we && tab_idx == IDX_W'(i))
                ent_q <= atb_entry_t'({stage_q, tab_lo});
        end
        assign tab_q[i] = ent_q;
    end

endmodule

// File: rtl/atb_lookup.sv
module atb_lookup
    import atb_pkg::*;
#(
    parameter int unsigned N_ENTRIES = 192
) (
    input  atb_entry_t       tab_q [N_ENTRIES],
    input  logic [BLK_W-1:0] vblk,
    input  logic             is_dma,
    output atb_result_t      res
);

    atb_entry_t       sel;
    logic             found;
    logic [BLK_W-1:0] m;

    // Scan downward so the lowest covering index is the last one kept
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (covers(tab_q[i], vblk)) begin
                found = 1'b1;
                sel   = tab_q[i];
            end
        end
    end

    always_comb begin
        m       = low_mask(sel.size);
        res.ok  = found && well_formed(sel) && allows(sel.rights, is_dma);
        res.iv  = sel.iv;
        res.dev = sel.dev;
        res.pblk = (sel.pblk & ~m) | (vblk & m);
    end

endmodule

// File: rtl/atb_errlog.sv
module atb_errlog
    import atb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fault,
    input  logic             is_dma,
    input  logic [CAP_W-1:0] addr_hi,
    input  logic [1:0]       clr,
    output logic             err_pio,
    output logic             err_dma,
    output logic [CAP_W-1:0] err_addr
);

    logic keep_pio, keep_dma;

    assign keep_pio = err_pio & ~clr[0];
    assign keep_dma = err_dma & ~clr[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            err_pio  <= 1'b0;
            err_dma  <= 1'b0;
            err_addr <= '0;
        end else begin
            err_pio <= keep_pio | (fault & ~is_dma);
            err_dma <= keep_dma | (fault & is_dma);
            if (fault && !keep_pio && !keep_dma)
                err_addr <= addr_hi;
        end
    end

endmodule

// File: rtl/atb_xlate.sv
module atb_xlate
    import atb_pkg::*;
#(
    parameter int unsigned N_ENTRIES = 192
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          stage_we,
    input  logic [8:0]                    stage_d,
    input  logic                          tab_we,
    input  logic [$clog2(N_ENTRIES)-1:0]  tab_idx,
    input  logic [31:0]                   tab_lo,
    input  logic                          req_valid,
    input  logic                          req_dma,
    input  logic [29:0]                   req_addr,
    input  logic [1:0]                    err_clr,
    output logic                          rsp_valid,
    output logic                          rsp_ok,
    output logic                          rsp_iv,
    output logic [1:0]                    rsp_dev,
    output logic [29:0]                   rsp_phys,
    output logic                          err_pio,
    output logic                          err_dma,
    output logic [21:0]                   err_addr
);

    atb_entry_t  tab_q [N_ENTRIES];
    atb_result_t res;
    logic        grant;

    atb_table #(.N_ENTRIES(N_ENTRIES)) u_table (
        .clk      (clk),
        .rst      (rst),
        .stage_we (stage_we),
        .stage_d  (stage_d),
        .tab_we   (tab_we),
        .tab_idx  (tab_idx),
        .tab_lo   (tab_lo),
        .tab_q    (tab_q)
    );

    atb_lookup #(.N_ENTRIES(N_ENTRIES)) u_lookup (
        .tab_q  (tab_q),
        .vblk   (req_addr[ADDR_W-1:OFF_W]),
        .is_dma (req_dma),
        .res    (res)
    );

    atb_errlog u_errlog (
        .clk      (clk),
        .rst      (rst),
        .fault    (req_valid & ~res.ok),
        .is_dma   (req_dma),
        .addr_hi  (req_addr[ADDR_W-1:CAP_LO]),
        .clr      (err_clr),
        .err_pio  (err_pio),
        .err_dma  (err_dma),
        .err_addr (err_addr)
    );

    assign grant = req_valid & res.ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_iv    <= 1'b0;
            rsp_dev   <= '0;
            rsp_phys  <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_ok    <= grant;
            rsp_iv    <= grant & res.iv;
            rsp_dev   <= grant ? res.dev : 2'd0;
            rsp_phys  <= grant ? {res.pblk, req_addr[OFF_W-1:0]} : '0;
        end
    end

endmodule

// File: rtl/atb_xlate_chk.sv
module atb_xlate_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_dma,
    input logic [1:0]  err_clr,
    input logic        rsp_valid,
    input logic        rsp_ok,
    input logic        rsp_iv,
    input logic [1:0]  rsp_dev,
    input logic [29:0] rsp_phys,
    input logic        err_pio,
    input logic        err_dma,
    input logic [21:0] err_addr
);

    a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rsp_valid && !err_pio && !err_dma && err_addr == '0));

    a_r4_one_cycle_response: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    a_r4_no_spurious_response: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    a_r8_device_in_range: assert property (@(posedge clk) disable iff (rst)
        rsp_ok |-> rsp_dev != 2'd3);

    a_r9_refusal_is_empty: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ok) |-> (!rsp_iv && rsp_dev == 2'd0 && rsp_phys == '0));

    a_r9_dma_refusal_flags: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_dma) |=> (rsp_ok || err_dma));

    a_r9_pio_refusal_flags: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_dma) |=> (rsp_ok || err_pio));

    a_r10_pio_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_pio && !err_clr[0]) |=> err_pio);

    a_r10_dma_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_dma && !err_clr[1]) |=> err_dma);

    a_r10_capture_holds: assert property (@(posedge clk) disable iff (rst)
        ((err_pio || err_dma) && err_clr == 2'b00) |=> $stable(err_addr));

endmodule

bind atb_xlate atb_xlate_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_dma   (req_dma),
    .err_clr   (err_clr),
    .rsp_valid (rsp_valid),
    .rsp_ok    (rsp_ok),
    .rsp_iv    (rsp_iv),
    .rsp_dev   (rsp_dev),
    .rsp_phys  (rsp_phys),
    .err_pio   (err_pio),
    .err_dma   (err_dma),
    .err_addr  (err_addr)
);

// File: tb/atb_xlate_test.sv
module atb_xlate_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        stage_we;
    logic [8:0]  stage_d;
    logic        tab_we;
    logic [7:0]  tab_idx;
    logic [31:0] tab_lo;
    logic        req_valid;
    logic        req_dma;
    logic [29:0] req_addr;
    logic [1:0]  err_clr;
    logic        rsp_valid, rsp_ok, rsp_iv, err_pio, err_dma;
    logic [1:0]  rsp_dev;
    logic [29:0] rsp_phys;
    logic [21:0] err_addr;

    always #5 clk = ~clk;

    atb_xlate uut (
        .clk(clk), .rst(rst), .stage_we(stage_we), .stage_d(stage_d),
        .tab_we(tab_we), .tab_idx(tab_idx), .tab_lo(tab_lo),
        .req_valid(req_valid), .req_dma(req_dma), .req_addr(req_addr),
        .err_clr(err_clr), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
        .rsp_iv(rsp_iv), .rsp_dev(rsp_dev), .rsp_phys(rsp_phys),
        .err_pio(err_pio), .err_dma(err_dma), .err_addr(err_addr)
    );

    // Behavioural reference state
    logic [40:0] m_tab [192];
    logic [8:0]  m_stage;
    logic        m_valid, m_ok, m_iv, m_pio, m_dma;
    logic [1:0]  m_dev;
    logic [29:0] m_phys;
    logic [21:0] m_addr;

    int    errors = 0;
    int    checks = 0;
    string cur_req = "R1";

    task automatic model_step();
        int hit;
        int sz, vb, ev, pb;
        logic ok, fault, kp, kd;
        if (rst) begin
            for (int i = 0; i < 192; i++) m_tab[i] = '0;
            m_stage = '0;
            {m_valid, m_ok, m_iv, m_pio, m_dma} = '0;
            m_dev = '0; m_phys = '0; m_addr = '0;
        end else begin
            hit = -1;
            vb  = int'(req_addr[29:14]);
            for (int i = 0; i < 192; i++) begin
                sz = int'(m_tab[i][35:32]);
                ev = int'(m_tab[i][15:0]);
                if ((ev >> sz) == (vb >> sz)) begin hit = i; break; end
            end
            ok = 1'b0;
            sz = 0;
            if (hit >= 0) begin
                sz = int'(m_tab[hit][35:32]);
                ok = req_dma ? m_tab[hit][36] : m_tab[hit][37];
                if (m_tab[hit][39:38] == 2'd3) ok = 1'b0;
                if (m_tab[hit][40] && (sz != 0 || m_tab[hit][37:36] != 2'b11)) ok = 1'b0;
            end
            ok = ok && req_valid;
            m_valid = req_valid;
            m_ok    = ok;
            m_iv    = ok ? m_tab[hit][40] : 1'b0;
            m_dev   = ok ? m_tab[hit][39:38] : 2'd0;
            if (ok) begin
                pb = int'(m_tab[hit][31:16]);
                pb = ((pb >> sz) << sz) | (vb & ((1 << sz) - 1));
                m_phys = {pb[15:0], req_addr[13:0]};
            end else m_phys = '0;
            fault = req_valid && !ok;
            kp = m_pio && !err_clr[0];
            kd = m_dma && !err_clr[1];
            if (fault && !kp && !kd) m_addr = req_addr[29:8];
            m_pio = kp || (fault && !req_dma);
            m_dma = kd || (fault && req_dma);
            if (tab_we && tab_idx < 8'd192) m_tab[tab_idx] = {m_stage, tab_lo};
            if (stage_we) m_stage = stage_d;
        end
    endtask

    task automatic compare();
        logic [58:0] got, exp;
        got = {rsp_valid, rsp_ok, rsp_iv, rsp_dev, rsp_phys, err_pio, err_dma, err_addr};
        exp = {m_valid, m_ok, m_iv, m_dev, m_phys, m_pio, m_dma, m_addr};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: {valid,ok,iv,dev,phys,pio,dma,addr} got %h expected %h",
                     cur_req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1 model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        stage_we = 0; tab_we = 0; req_valid = 0; req_dma = 0; err_clr = 0;
    endtask

    function automatic logic [8:0] up(input logic iv, input logic [1:0] dev,
                                      input logic [1:0] rt, input logic [3:0] sz);
        return {iv, dev, rt, sz};
    endfunction

    task automatic put(input int idx, input logic [8:0] u, input logic [15:0] pb,
                       input logic [15:0] vb);
        idle(); stage_we = 1; stage_d = u; tick();
        idle(); tab_we = 1; tab_idx = 8'(idx); tab_lo = {pb, vb}; tick();
        idle();
    endtask

    task automatic look(input logic [15:0] vb, input logic [13:0] off, input logic dma);
        idle(); req_valid = 1; req_dma = dma; req_addr = {vb, off}; tick();
        idle(); tick();
    endtask

    task automatic clear(input logic [1:0] c);
        idle(); err_clr = c; tick(); idle();
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1; idle(); stage_d = 0; tab_idx = 0; tab_lo = 0; req_addr = 0;
        @(negedge clk);
        cur_req = "R1"; tick(); tick();
        rst = 0; tick();
        look(16'h0000, 14'h0123, 1'b0);            // R1: zero table refuses PIO

        cur_req = "R10"; look(16'h0abc, 14'h0000, 1'b1);  // second fault: address holds
        clear(2'b01);                               // PIO cleared, DMA still set
        look(16'h0111, 14'h3f00, 1'b0);            // still holds
        clear(2'b11);

        cur_req = "R2";
        put(0, up(0, 2'd1, 2'b11, 4'd0), 16'h0200, 16'h0010);
        idle(); stage_we = 1; stage_d = up(0, 2'd3, 2'b00, 4'd5); tick(); idle();
        look(16'h0010, 14'h0042, 1'b0);            // R2: entry unaffected by later stage
        cur_req = "R3"; look(16'h0010, 14'h3fff, 1'b1);
        cur_req = "R4";
        put(1, up(0, 2'd2, 2'b10, 4'd2), 16'h0401, 16'h0021);
        look(16'h0023, 14'h1abc, 1'b0);            // R4: offset bits pass through
        cur_req = "R3"; look(16'h0020, 14'h0001, 1'b0);
        look(16'h0024, 14'h0000, 1'b0);            // R3/R7: just past region end
        cur_req = "R5"; look(16'h0022, 14'h0000, 1'b1);   // PIO-only entry, DMA refused
        clear(2'b11);
        put(2, up(0, 2'd0, 2'b01, 4'd0), 16'h0777, 16'h0050);
        look(16'h0050, 14'h0008, 1'b1);
        look(16'h0050, 14'h0008, 1'b0);
        clear(2'b11);

        cur_req = "R6";
        put(5, up(0, 2'd0, 2'b11, 4'd0), 16'h0999, 16'h0020);
        look(16'h0020, 14'h0100, 1'b1);            // entry 1 wins and refuses DMA
        put(6, up(0, 2'd1, 2'b11, 4'd0), 16'h0aaa, 16'h0060);
        put(9, up(0, 2'd2, 2'b11, 4'd3), 16'h0bb0, 16'h0060);
        look(16'h0060, 14'h0005, 1'b1);            // entry 6 over entry 9
        look(16'h0063, 14'h0005, 1'b1);            // only entry 9
        clear(2'b11);

        cur_req = "R7"; look(16'h4321, 14'h2222, 1'b1);
        clear(2'b11);

        cur_req = "R8";
        put(3, up(1, 2'd0, 2'b11, 4'd0), 16'h0300, 16'h0030);
        look(16'h0030, 14'h0010, 1'b0);            // valid IV entry
        put(4, up(1, 2'd0, 2'b11, 4'd1), 16'h0310, 16'h0040);
        look(16'h0040, 14'h0010, 1'b1);            // IV with size 1
        clear(2'b11);
        put(7, up(1, 2'd0, 2'b10, 4'd0), 16'h0320, 16'h0044);
        look(16'h0044, 14'h0010, 1'b0);            // IV with rights 10
        clear(2'b11);
        put(8, up(0, 2'd3, 2'b11, 4'd0), 16'h0330, 16'h0048);
        look(16'h0048, 14'h0010, 1'b1);            // device 3
        clear(2'b11);

        cur_req = "R9"; look(16'h5555, 14'h0000, 1'b0);
        look(16'h6666, 14'h0000, 1'b1);

        cur_req = "R10";
        idle(); err_clr = 2'b11; req_valid = 1; req_dma = 1;
        req_addr = {16'h7777, 14'h0abc}; tick();   // fault beats clear, recapture
        idle(); tick();
        clear(2'b10); tick();

        cur_req = "R11";
        put(200, up(0, 2'd1, 2'b11, 4'd0), 16'h0123, 16'h0070);
        look(16'h0070, 14'h0000, 1'b0);
        clear(2'b11);
        cur_req = "R4";
        put(191, up(0, 2'd2, 2'b01, 4'd4), 16'h1230, 16'h7000);
        look(16'h700f, 14'h0abc, 1'b1);
        put(0, up(0, 2'd2, 2'b10, 4'd15), 16'hf000, 16'h8000);   // rewrite, largest region
        look(16'hfffe, 14'h0001, 1'b0);
        tick();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule